// File: doc/BRIEF.md
# Memory-to-Stream DMA Source Channel

This block fetches a run of 32-bit words from memory and plays them out on a valid/ready stream. Software first loads a start address. It then writes a size word that holds a word count and an end-of-packet flag. That size write is the command: it loads the live counter and starts the fetch. Read requests go out on a simple request/response memory port, one per word, with the address stepping by 4 each time. Responses return in order, one cycle or more after their request. They land in a small internal FIFO, which feeds the output stream.

Memory responses cannot be stalled. The channel therefore issues a request only when a FIFO slot is free for its answer: requests in flight plus words already held in the FIFO never exceed the FIFO depth. The stream obeys normal back-pressure rules. A word transfers on a cycle where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, the data and last outputs hold still and valid stays up. `m_ready` may stay low for any length of time without loss of data.

Two sticky status bits report completion. MEM_DONE means every response has been captured. DONE means every word has left on the stream. Software clears each bit by writing 1 to it. A busy bit shows that a command is in progress.

Top module: `dma_src_channel`

## Requirements
- R1: After reset, the address register (offset 0x0), the size register (offset 0x4) and the status register (offset 0x8) read zero, and neither `m_valid` nor `mem_req_valid` is high.
- R2: In the size register, bits 28:2 hold the word count and bit 0 holds the end-of-packet flag. Bits 31:29 and bit 1 read as zero, whatever value was written to them.
- R3: A size write while idle starts a command. The channel issues exactly `count` read requests at start, start+4, start+8 and so on, and it sends the response words on the stream in request order.
- R4: While a command runs, the count field of the size register reads the words not yet captured. It drops by one for each response written into the FIFO and reads 0 at the end.
- R5: A size write with a count of zero sets both DONE (status bit 0) and MEM_DONE (status bit 1) at once. It issues no request and sends no stream word.
- R6: With the end-of-packet flag set, `m_last` is high together with `m_valid` on the final word of the command and on no other word. With the flag clear, `m_last` is never high.
- R7: MEM_DONE is set once the final response has been written into the FIFO. DONE is set once the final word has been accepted on the stream. MEM_DONE can therefore be set while DONE is still clear.
- R8: Requests in flight plus FIFO occupancy never exceed the FIFO depth (4 by default). A response never arrives at a full FIFO.
- R9: DONE and MEM_DONE stay set until software writes 1 to their own bit in the status register. Writing 0 to a bit leaves it unchanged.
- R10: Status bit 2 reads 1 while a command is in progress. A size write during that time is ignored: it changes neither the count, the flag nor the number of words sent.
- R11: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values. While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Read response valid (in order, no stall) |
| mem_rsp_data | input | 32 | Read response data |
| m_valid | output | 1 | Stream word valid |
| m_ready | input | 1 | Stream sink ready |
| m_data | output | 32 | Stream data |
| m_last | output | 1 | Final word of a flagged command |
| done_o | output | 1 | DONE status bit |
| mem_done_o | output | 1 | MEM_DONE status bit |
| busy_o | output | 1 | Command in progress |

## Verification
The bound assertions check, on every cycle, several rules that must always hold. Stream and request outputs stay stable under back-pressure. No response enters a full FIFO. `m_last` is never high without `m_valid`. Requests go out only while busy. The count drops by exactly one per captured word. Both status bits stay set until software clears them. Other behaviour needs the bench's scenarios, because only a whole command shows it: the request address sequence, the order of the stream data, where last falls, the zero-length start, a size write ignored while busy, and the gap between MEM_DONE and DONE when the sink is stalled.

// File: rtl/dma_src_pkg.sv
package dma_src_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int SIZE_LSB = 2;
  localparam int SIZE_MSB = 28;
  localparam int CNT_W = SIZE_MSB - SIZE_LSB + 1;
  localparam int EOP_BIT = 0;

  localparam logic [3:0] OFS_ADDR = 4'h0;
  localparam logic [3:0] OFS_SIZE = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;

  localparam int ST_DONE = 0;
  localparam int ST_MEMDONE = 1;
  localparam int ST_BUSY = 2;

  typedef struct packed {
    logic              final_w;
    logic [DATA_W-1:0] data;
  } fifo_ent_t;
endpackage

// File: rtl/dma_src_fifo.sv
module dma_src_fifo #(
  parameter int W = 33,
  parameter int DEPTH = 4,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PW'(1);
  endfunction

  assign empty    = (count == '0);
  assign pop_data = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dma_src_reader.sv
module dma_src_reader #(
  parameter int AW = 32,
  parameter int CNTW = 27,
  parameter int DEPTH = 4,
  parameter int OCW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  input  logic [CNTW-1:0] start_cnt,
  input  logic [OCW-1:0]  fifo_count,
  input  logic            rsp_valid,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [AW-1:0]   req_addr
);
  localparam logic [OCW:0] SLOTS = (OCW + 1)'(DEPTH);

  logic [CNTW-1:0] req_left;
  logic [AW-1:0]   ptr;
  logic [OCW-1:0]  outst;
  logic [OCW:0]    inflight;
  logic            hs;

  assign inflight  = {1'b0, outst} + {1'b0, fifo_count};
  assign req_valid = (req_left != '0) && (inflight < SLOTS);
  assign req_addr  = ptr;
  assign hs        = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_left <= '0;
      ptr      <= '0;
      outst    <= '0;
    end else begin
      if (start) begin
        req_left <= start_cnt;
        ptr      <= start_addr;
      end else if (hs) begin
        req_left <= req_left - CNTW'(1);
        ptr      <= ptr + AW'(4);
      end
      case ({hs, rsp_valid})
        2'b10:   outst <= outst + OCW'(1);
        2'b01:   outst <= outst - OCW'(1);
        default: outst <= outst;
      endcase
    end
  end
endmodule

// File: rtl/dma_src_channel.sv
module dma_src_channel
  import dma_src_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic              done_o,
  output logic              mem_done_o,
  output logic              busy_o
);
  localparam int OCW = $clog2(DEPTH + 1);
  localparam int ENT_W = $bits(fifo_ent_t);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  size_cnt;
  logic              eop_q, busy_q, done_q, mem_done_q;

  logic              wr_size, wr_stat, start, zero_start;
  logic [CNT_W-1:0]  new_cnt;
  logic              fifo_push, fifo_pop, fifo_empty, final_pop, final_push;
  logic [OCW-1:0]    fifo_count;
  fifo_ent_t         push_ent, head;

  assign new_cnt    = reg_wdata[SIZE_MSB:SIZE_LSB];
  assign wr_size    = reg_wr_en && (reg_addr == OFS_SIZE);
  assign wr_stat    = reg_wr_en && (reg_addr == OFS_STAT);
  assign start      = wr_size && !busy_q;
  assign zero_start = start && (new_cnt == '0);

  assign fifo_push  = mem_rsp_valid && busy_q;
  assign final_push = fifo_push && (size_cnt == CNT_W'(1));
  assign push_ent   = '{final_w: (size_cnt == CNT_W'(1)), data: mem_rsp_data};

  assign m_valid    = !fifo_empty;
  assign m_data     = head.data;
  assign m_last     = m_valid && head.final_w && eop_q;
  assign fifo_pop   = m_valid && m_ready;
  assign final_pop  = fifo_pop && head.final_w;

  dma_src_reader #(
    .AW(ADDR_W), .CNTW(CNT_W), .DEPTH(DEPTH), .OCW(OCW)
  ) i_reader (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (addr_q),
    .start_cnt  (new_cnt),
    .fifo_count (fifo_count),
    .rsp_valid  (fifo_push),
    .req_valid  (mem_req_valid),
    .req_ready  (mem_req_ready),
    .req_addr   (mem_req_addr)
  );

  logic [ENT_W-1:0] head_bits;
  assign head = fifo_ent_t'(head_bits);

  dma_src_fifo #(
    .W(ENT_W), .DEPTH(DEPTH), .CW(OCW)
  ) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fifo_push),
    .push_data (push_ent),
    .pop       (fifo_pop),
    .pop_data  (head_bits),
    .empty     (fifo_empty),
    .count     (fifo_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      size_cnt   <= '0;
      eop_q      <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      mem_done_q <= 1'b0;
    end else begin
      if (reg_wr_en && (reg_addr == OFS_ADDR)) addr_q <= reg_wdata;

      if (start) begin
        size_cnt <= new_cnt;
        eop_q    <= reg_wdata[EOP_BIT];
      end else if (fifo_push) begin
        size_cnt <= size_cnt - CNT_W'(1);
      end

      if (start && !zero_start) busy_q <= 1'b1;
      else if (final_pop)       busy_q <= 1'b0;

      done_q     <= (done_q && !(wr_stat && reg_wdata[ST_DONE]))
                    || final_pop || zero_start;
      mem_done_q <= (mem_done_q && !(wr_stat && reg_wdata[ST_MEMDONE]))
                    || final_push || zero_start;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_ADDR: reg_rdata = addr_q;
      OFS_SIZE: reg_rdata = {3'b000, size_cnt, 1'b0, eop_q};
      OFS_STAT: reg_rdata = {29'd0, busy_q, mem_done_q, done_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign done_o     = done_q;
  assign mem_done_o = mem_done_q;
  assign busy_o     = busy_q;
endmodule

// File: rtl/dma_src_checker.sv
module dma_src_checker #(
  parameter int DEPTH = 4,
  parameter int OCW = $clog2(DEPTH + 1),
  parameter int CNTW = 27
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_en,
  input logic [3:0]      reg_addr,
  input logic [1:0]      clr_bits,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [31:0]     mem_req_addr,
  input logic            m_valid,
  input logic            m_ready,
  input logic [31:0]     m_data,
  input logic            m_last,
  input logic            busy,
  input logic            done,
  input logic            mem_done,
  input logic            fifo_push,
  input logic [OCW-1:0]  fifo_count,
  input logic [CNTW-1:0] size_cnt
);
  logic stat_wr;
  assign stat_wr = reg_wr_en && (reg_addr == 4'h8);

  assert_stream_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> fifo_count < OCW'(DEPTH));

  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid);

  assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(stat_wr && clr_bits[0]) |=> done);

  assert_memdone_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done && !(stat_wr && clr_bits[1]) |=> mem_done);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fifo_push |=> size_cnt == $past(size_cnt) - CNTW'(1));
endmodule

bind dma_src_channel dma_src_checker #(.DEPTH(DEPTH), .OCW(OCW), .CNTW(CNT_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr_en     (reg_wr_en),
  .reg_addr      (reg_addr),
  .clr_bits      (reg_wdata[1:0]),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .m_valid       (m_valid),
  .m_ready       (m_ready),
  .m_data        (m_data),
  .m_last        (m_last),
  .busy          (busy_q),
  .done          (done_q),
  .mem_done      (mem_done_q),
  .fifo_push     (fifo_push),
  .fifo_count    (fifo_count),
  .size_cnt      (size_cnt)
);

// File: tb/test_dma_src_channel.sv
`timescale 1ns/1ps
module test_dma_src_channel;
  localparam int DEPTH = 4;
  localparam logic [31:0] MAGIC = 32'hC3C3_0000;
  localparam int NV = 5;
  localparam int          V_CNT [NV] = '{5, 1, 6, 9, 3};
  localparam logic        V_EOP [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] V_ADR [NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h0040, 32'hFFF0};
  localparam logic [3:0]  V_RQM [NV] = '{4'd0, 4'd1, 4'd3, 4'd2, 4'd1};
  localparam logic [3:0]  V_OM  [NV] = '{4'd0, 4'd2, 4'd1, 4'd3, 4'd0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic m_valid, m_ready = 1'b0, m_last;
  logic [31:0] m_data;
  logic done_o, mem_done_o, busy_o;

  int checks = 0, errors = 0;
  logic [3:0] rq_mask = 0, o_mask = 0;
  logic out_hold = 1'b0;
  int cyc = 0;

  logic [31:0] rx_data [64];
  logic        rx_last [64];
  logic [31:0] rq_log  [64];
  int rx_n = 0, rq_n = 0, rq_tot = 0, pop_tot = 0;
  logic occ_err = 1'b0, hold_err = 1'b0, hold_prev = 1'b0, prev_last = 1'b0;
  logic [31:0] prev_data = '0;

  always #2.5 clk = ~clk;

  dma_src_channel #(.DEPTH(DEPTH)) i_dma_src_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .done_o(done_o),
    .mem_done_o(mem_done_o), .busy_o(busy_o)
  );

  // Memory model and ready patterns
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= rst_n && mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem_req_addr ^ MAGIC;
    mem_req_ready <= ((cyc[3:0] & rq_mask) == 4'd0);
    m_ready       <= !out_hold && ((cyc[3:0] & o_mask) == 4'd0);
  end

  // Monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev && (!m_valid || m_data != prev_data || m_last != prev_last))
        hold_err = 1'b1;
      hold_prev = m_valid && !m_ready;
      prev_data = m_data;
      prev_last = m_last;
      if (mem_req_valid && mem_req_ready) begin
        if (rq_n < 64) rq_log[rq_n] = mem_req_addr;
        rq_n++; rq_tot++;
      end
      if (m_valid && m_ready) begin
        if (rx_n < 64) begin rx_data[rx_n] = m_data; rx_last[rx_n] = m_last; end
        rx_n++; pop_tot++;
      end
      if (rq_tot - pop_tot > DEPTH) occ_err = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic clear_logs();
    @(negedge clk);
    #1;
    rx_n = 0; rq_n = 0; occ_err = 1'b0; hold_err = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      reg_read(4'h8, s);
      if (!s[2]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_stream(input int n, input logic eop, input logic [31:0] a, input string tag);
    bit dok = (rx_n == n);
    bit aok = (rq_n == n);
    bit lok = 1'b1;
    for (int i = 0; i < n && i < 64; i++) begin
      if (rx_data[i] != ((a + 32'(4 * i)) ^ MAGIC)) dok = 1'b0;
      if (rq_log[i] != a + 32'(4 * i)) aok = 1'b0;
      if (rx_last[i] != (eop && (i == n - 1))) lok = 1'b0;
    end
    check(aok, {"R3 request addresses ", tag}, 32'(rq_n), 32'(n));
    check(dok, {"R3 stream data/order ", tag}, 32'(rx_n), 32'(n));
    check(lok, {"R6 last placement ", tag}, 32'(eop), 32'(eop));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(4'h0, r); check(r == 0, "R1 address reg", r, 0);
    reg_read(4'h4, r); check(r == 0, "R1 size reg", r, 0);
    reg_read(4'h8, r); check(r == 0, "R1 status reg", r, 0);
    check(!m_valid && !mem_req_valid, "R1 outputs idle", {m_valid, mem_req_valid}, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      rq_mask = V_RQM[v]; o_mask = V_OM[v];
      clear_logs();
      reg_write(4'h0, V_ADR[v]);
      reg_write(4'h4, (32'(V_CNT[v]) << 2) | 32'(V_EOP[v]));
      wait_idle();
      check_stream(V_CNT[v], V_EOP[v], V_ADR[v], "vector");
      reg_read(4'h8, r); check(r == 32'h3, "R7 status after vector", r, 32'h3);
      reg_read(4'h4, r); check(r == 32'(V_EOP[v]), "R4 size reads zero at end", r, 32'(V_EOP[v]));
      check(!occ_err, "R8 inflight bound", 32'(occ_err), 0);
      check(!hold_err, "R11 stream hold", 32'(hold_err), 0);
      reg_write(4'h8, 32'h3);
      reg_read(4'h8, r); check(r == 0, "R9 clear both bits", r, 0);
    end
    rq_mask = 0; o_mask = 0;

    // R2/R10/R4/R7: stalled sink, reserved bits, ignored write
    out_hold = 1'b1;
    clear_logs();
    reg_write(4'h0, 32'h0000_0500);
    reg_write(4'h4, 32'hE000_000A);
    reg_read(4'h4, r); check(r == 32'h8, "R2 reserved bits read zero", r, 32'h8);
    reg_read(4'h8, r); check(r == 32'h4, "R10 busy bit", r, 32'h4);
    reg_write(4'h4, 32'h0000_001D);
    repeat (12) @(negedge clk);
    reg_read(4'h4, r); check(r == 32'h0, "R4/R10 count drained, write ignored", r, 0);
    reg_read(4'h8, r); check(r == 32'h6, "R7 mem_done before done", r, 32'h6);
    check(m_valid && !m_last, "R6 no last without flag", {m_valid, m_last}, 32'h2);
    out_hold = 1'b0;
    wait_idle();
    check_stream(2, 1'b0, 32'h500, "stalled");
    reg_read(4'h8, r); check(r == 32'h3, "R7 done after drain", r, 32'h3);
    check(!hold_err, "R11 hold during stall", 32'(hold_err), 0);
    reg_write(4'h8, 32'h3);

    // R8: credit limit with a stalled sink
    out_hold = 1'b1;
    clear_logs();
    reg_write(4'h0, 32'h0000_0800);
    reg_write(4'h4, 32'h0000_0028);
    repeat (30) @(negedge clk);
    check(rq_n == DEPTH, "R8 requests stop at depth", 32'(rq_n), 32'(DEPTH));
    reg_read(4'h4, r); check(r == 32'h18, "R4 remaining count", r, 32'h18);
    out_hold = 1'b0;
    wait_idle();
    check_stream(10, 1'b0, 32'h800, "credit");
    check(!occ_err, "R8 inflight bound credit", 32'(occ_err), 0);
    reg_write(4'h8, 32'h3);

    // R5 zero length, R9 write-one-to-clear per bit
    clear_logs();
    reg_write(4'h4, 32'h0000_0001);
    reg_read(4'h8, r); check(r == 32'h3, "R5 zero start sets both", r, 32'h3);
    repeat (8) @(negedge clk);
    check(rq_n == 0 && rx_n == 0, "R5 no traffic", 32'(rq_n + rx_n), 0);
    reg_write(4'h8, 32'h0);
    reg_read(4'h8, r); check(r == 32'h3, "R9 write zero keeps bits", r, 32'h3);
    reg_write(4'h8, 32'h1);
    reg_read(4'h8, r); check(r == 32'h2, "R9 clear done only", r, 32'h2);
    reg_write(4'h8, 32'h2);
    reg_read(4'h8, r); check(r == 32'h0, "R9 clear mem_done", r, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule